// File: doc/BRIEF.md
# Overlapping Register Window File

This block is a register file for a processor core that exposes 32 architectural registers through a 5-bit specifier. Eight of these registers are global and sit in the same storage whatever the window. The other 24 are taken from the active window. The physical windows form a ring. Each window shares its outgoing group of eight with the incoming group of the next window. Because of this, a procedure call can hand arguments to the callee, and results back to the caller, in registers and without any copying.

The core drives two combinational read ports and one write port. All three ports use architectural specifiers. A call strobe moves the current window pointer forward by one, and a return strobe moves it back by one. A valid-window mask has one bit for each window and records which windows hold live frames. When a call or return cannot proceed, a small controller rejects it and raises an overflow or underflow flag for one cycle. Any spill to memory or fill from memory is left to the surrounding logic, which acts on these flags.

The controller has three named states:
- `ST_OK`: the last cycle held no fault.
- `ST_OVF`: a call was just rejected.
- `ST_UNF`: a return was just rejected.

The next state is worked out again every cycle, so each fault state lasts exactly one cycle:
- A lone call whose target window is valid goes to `ST_OVF`.
- A lone return whose target window is invalid goes to `ST_UNF`.
- Every other cycle, including an accepted call or return, goes to `ST_OK`.

Top module: `regwin_file`

## Requirements
- R1: Reset (asynchronous, active-low) sets the window pointer to 0 and the mask to only bit 0 set. It clears both flags and makes every register read as zero. After reset, the mask bit of the current window is always set.
- R2: Specifiers 0 to 7 select global registers, which hold the same storage in every window.
- R3: Specifiers 24 to 31 of window k select the same storage as specifiers 8 to 15 of window k+1, index for index.
- R4: Specifiers 16 to 23 are private to each window. A write to them in one window is not visible in any other window.
- R5: The windows form a ring. Window NWIN-1's specifiers 24 to 31 alias window 0's specifiers 8 to 15, and the pointer moves from NWIN-1 to 0 when it advances.
- R6: A call on its own, where the mask bit of window (pointer+1) mod NWIN is clear, takes effect at the next edge. The pointer moves to that window, its mask bit is set, and the overflow flag stays low.
- R7: A call on its own, where the target mask bit is already set, is rejected. The pointer and mask do not change, and the overflow flag is high for exactly the next cycle.
- R8: A return on its own has two outcomes. If the mask bit of window (pointer-1) mod NWIN is set, the current window's bit is cleared and the pointer moves back. Otherwise the pointer and mask do not change, and the underflow flag is high for exactly the next cycle.
- R9: A call and a return in the same cycle have no effect on the pointer, the mask or either flag.
- R10: When a read port selects the register being written in the same cycle, it returns the new write data in that cycle (write-first).
- R11: A write lands at the clock edge. It is addressed through the window that is active in the cycle of the write, even when a call or return moves the pointer at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ra_sel | input | 5 | Read port A architectural specifier |
| ra_data | output | DW | Read port A data |
| rb_sel | input | 5 | Read port B architectural specifier |
| rb_data | output | DW | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 5 | Write architectural specifier |
| wr_data | input | DW | Write data |
| call_i | input | 1 | Call strobe: advance window |
| ret_i | input | 1 | Return strobe: retreat window |
| cwp_o | output | $clog2(NWIN) | Current window pointer |
| mask_o | output | NWIN | Valid-window mask, bit w for window w |
| ovf_o | output | 1 | Call rejected in previous cycle |
| unf_o | output | 1 | Return rejected in previous cycle |

## Verification
The window controller is driven from a table of call and return strobes. This sequence fills every window and then hits overflow at the ring's wrap. It unwinds back to window 0, hits underflow there, and includes a cycle with both strobes asserted. Because the flags are checked beside the pointer and mask, the test can tell a rejected move from a silent no-op.

Data patterns are written through one window and read through another. This separates the three kinds of storage:
- Globals must persist across windows.
- The outgoing group must appear as the next window's incoming group, including across the ring wrap.
- Locals must stay private.

A write issued in the same cycle as a call shows whether the address was translated with the old pointer or the new one. A read and a write to the same specifier in the same cycle exercise the bypass.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
    localparam int SEL_W    = 5;
    localparam int N_GLOBAL = 8;
    localparam int WIN_STEP = 16;

    typedef enum logic [1:0] {
        ST_OK  = 2'd0,
        ST_OVF = 2'd1,
        ST_UNF = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/regwin_xlate.sv
module regwin_xlate
    import regwin_pkg::*;
#(
    parameter int NWIN = 4,
    parameter int CW   = 2,
    parameter int PW   = 7
) (
    input  logic [CW-1:0]    win,
    input  logic [SEL_W-1:0] sel,
    output logic [PW-1:0]    phys
);
    localparam int SPAN = WIN_STEP * NWIN;

    int off;

    always_comb begin
        off = 0;
        if (int'(sel) < N_GLOBAL) begin
            phys = PW'(sel);
        end else begin
            off = int'(win) * WIN_STEP + int'(sel) - N_GLOBAL;
            if (off >= SPAN) begin
                off = off - SPAN;
            end
            phys = PW'(off + N_GLOBAL);
        end
    end
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
    import regwin_pkg::*;
#(
    parameter int NWIN = 4,
    parameter int CW   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            call_i,
    input  logic            ret_i,
    output logic [CW-1:0]   cwp_o,
    output logic [NWIN-1:0] mask_o,
    output logic            ovf_o,
    output logic            unf_o
);
    ctl_state_e      state_q, state_d;
    logic [CW-1:0]   cwp_q, cwp_d, cwp_up, cwp_dn;
    logic [NWIN-1:0] mask_q, mask_d;
    logic            lone_call, lone_ret;

    assign cwp_up    = (int'(cwp_q) == NWIN - 1) ? '0 : cwp_q + CW'(1);
    assign cwp_dn    = (cwp_q == '0) ? CW'(NWIN - 1) : cwp_q - CW'(1);
    assign lone_call = call_i && !ret_i;
    assign lone_ret  = ret_i && !call_i;

    always_comb begin
        state_d = ST_OK;
        cwp_d   = cwp_q;
        mask_d  = mask_q;
        if (lone_call) begin
            if (mask_q[cwp_up]) begin
                state_d = ST_OVF;
            end else begin
                cwp_d          = cwp_up;
                mask_d[cwp_up] = 1'b1;
            end
        end else if (lone_ret) begin
            if (!mask_q[cwp_dn]) begin
                state_d = ST_UNF;
            end else begin
                cwp_d         = cwp_dn;
                mask_d[cwp_q] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OK;
            cwp_q   <= '0;
            mask_q  <= NWIN'(1);
        end else begin
            state_q <= state_d;
            cwp_q   <= cwp_d;
            mask_q  <= mask_d;
        end
    end

    always_comb begin
        ovf_o = 1'b0;
        unf_o = 1'b0;
        unique case (state_q)
            ST_OK:   ;
            ST_OVF:  ovf_o = 1'b1;
            ST_UNF:  unf_o = 1'b1;
            default: ;
        endcase
    end

    assign cwp_o  = cwp_q;
    assign mask_o = mask_q;

    // R1
    cur_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q[cwp_q]);
    // R6
    call_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lone_call && !mask_q[cwp_up]) |=> (cwp_q == $past(cwp_up)) && !ovf_o);
    // R7
    call_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lone_call && mask_q[cwp_up]) |=> ovf_o && $stable(cwp_q) && $stable(mask_q));
    // R8
    ret_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lone_ret && !mask_q[cwp_dn]) |=> unf_o && $stable(cwp_q) && $stable(mask_q));
    // R9
    both_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && ret_i) |=> $stable(cwp_q) && $stable(mask_q) && !ovf_o && !unf_o);
endmodule

// File: rtl/regwin_store.sv
module regwin_store #(
    parameter int NPHYS = 72,
    parameter int PW    = 7,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] ra_phys,
    output logic [DW-1:0] ra_data,
    input  logic [PW-1:0] rb_phys,
    output logic [DW-1:0] rb_data,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_phys,
    input  logic [DW-1:0] wr_data
);
    logic [DW-1:0] regs [NPHYS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++) begin
                regs[i] <= '0;
            end
        end else if (wr_en) begin
            regs[wr_phys] <= wr_data;
        end
    end

    always_comb begin
        ra_data = regs[ra_phys];
        if (wr_en && (wr_phys == ra_phys)) begin
            ra_data = wr_data;
        end
        rb_data = regs[rb_phys];
        if (wr_en && (wr_phys == rb_phys)) begin
            rb_data = wr_data;
        end
    end

    // R11
    write_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> regs[$past(wr_phys)] == $past(wr_data));
endmodule

// File: rtl/regwin_file.sv
module regwin_file
    import regwin_pkg::*;
#(
    parameter int NWIN = 4,
    parameter int DW   = 16,
    localparam int CW    = (NWIN > 1) ? $clog2(NWIN) : 1,
    localparam int NPHYS = N_GLOBAL + WIN_STEP * NWIN,
    localparam int PW    = $clog2(NPHYS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [4:0]      ra_sel,
    output logic [DW-1:0]   ra_data,
    input  logic [4:0]      rb_sel,
    output logic [DW-1:0]   rb_data,
    input  logic            wr_en,
    input  logic [4:0]      wr_sel,
    input  logic [DW-1:0]   wr_data,
    input  logic            call_i,
    input  logic            ret_i,
    output logic [CW-1:0]   cwp_o,
    output logic [NWIN-1:0] mask_o,
    output logic            ovf_o,
    output logic            unf_o
);
    localparam int NPORT = 3;

    logic [SEL_W-1:0] sel_v  [NPORT];
    logic [PW-1:0]    phys_v [NPORT];
    logic [CW-1:0]    cwp;

    assign sel_v[0] = ra_sel;
    assign sel_v[1] = rb_sel;
    assign sel_v[2] = wr_sel;

    regwin_ctrl #(.NWIN(NWIN), .CW(CW)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .call_i (call_i),
        .ret_i  (ret_i),
        .cwp_o  (cwp),
        .mask_o (mask_o),
        .ovf_o  (ovf_o),
        .unf_o  (unf_o)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_xl
        regwin_xlate #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_xl (
            .win  (cwp),
            .sel  (sel_v[p]),
            .phys (phys_v[p])
        );
    end

    regwin_store #(.NPHYS(NPHYS), .PW(PW), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_phys (phys_v[0]),
        .ra_data (ra_data),
        .rb_phys (phys_v[1]),
        .rb_data (rb_data),
        .wr_en   (wr_en),
        .wr_phys (phys_v[2]),
        .wr_data (wr_data)
    );

    assign cwp_o = cwp;

    // R2
    global_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel < 5'd8) |-> (int'(phys_v[2]) == int'(wr_sel)));
endmodule

// File: tb/regwin_file_tb.sv
module regwin_file_tb;
    localparam int NWIN = 4;
    localparam int DW   = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    ra_sel = '0, rb_sel = '0, wr_sel = '0;
    logic [DW-1:0] ra_data, rb_data, wr_data = '0;
    logic          wr_en = 1'b0, call_i = 1'b0, ret_i = 1'b0;
    logic [1:0]    cwp_o;
    logic [3:0]    mask_o;
    logic          ovf_o, unf_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    regwin_file #(.NWIN(NWIN), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ra_sel(ra_sel), .ra_data(ra_data),
        .rb_sel(rb_sel), .rb_data(rb_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .call_i(call_i), .ret_i(ret_i),
        .cwp_o(cwp_o), .mask_o(mask_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    // {call, ret, cwp, mask, ovf, unf} after the strobe cycle
    localparam logic [9:0] VEC [10] = '{
        {1'b0, 1'b1, 2'd0, 4'b0001, 1'b0, 1'b1},  // R8 underflow at window 0
        {1'b1, 1'b0, 2'd1, 4'b0011, 1'b0, 1'b0},  // R6
        {1'b1, 1'b0, 2'd2, 4'b0111, 1'b0, 1'b0},  // R6
        {1'b1, 1'b0, 2'd3, 4'b1111, 1'b0, 1'b0},  // R6
        {1'b1, 1'b0, 2'd3, 4'b1111, 1'b1, 1'b0},  // R7 overflow at ring wrap
        {1'b0, 1'b1, 2'd2, 4'b0111, 1'b0, 1'b0},  // R8
        {1'b1, 1'b1, 2'd2, 4'b0111, 1'b0, 1'b0},  // R9
        {1'b0, 1'b1, 2'd1, 4'b0011, 1'b0, 1'b0},  // R8
        {1'b0, 1'b1, 2'd0, 4'b0001, 1'b0, 1'b0},  // R8
        {1'b0, 1'b1, 2'd0, 4'b0001, 1'b0, 1'b1}   // R8 underflow again
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic op(input logic c, input logic r);
        @(negedge clk);
        call_i = c; ret_i = r;
        @(negedge clk);
        call_i = 1'b0; ret_i = 1'b0;
    endtask

    task automatic wr(input logic [4:0] idx, input logic [15:0] d, input logic with_call);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = idx; wr_data = d; call_i = with_call;
        @(negedge clk);
        wr_en = 1'b0; call_i = 1'b0;
    endtask

    task automatic rd(input string req, input logic [4:0] idx, input logic [15:0] exp);
        @(negedge clk);
        ra_sel = idx;
        #1;
        chk(req, ra_data, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 cwp", 16'(cwp_o), 16'd0);
        chk("R1 mask", 16'(mask_o), 16'h0001);
        chk("R1 flags", {14'd0, ovf_o, unf_o}, 16'd0);
        rd("R1 reg", 5'd20, 16'h0000);

        // table of window moves
        for (int i = 0; i < 10; i++) begin
            op(VEC[i][9], VEC[i][8]);
            chk($sformatf("R6/R7/R8/R9 vec%0d cwp", i), 16'(cwp_o), 16'(VEC[i][7:6]));
            chk($sformatf("R6/R7/R8/R9 vec%0d mask", i), 16'(mask_o), 16'(VEC[i][5:2]));
            chk($sformatf("R6/R7/R8/R9 vec%0d flags", i), {14'd0, ovf_o, unf_o}, {14'd0, VEC[i][1:0]});
        end
        @(negedge clk);
        chk("R7 ovf one cycle", {15'd0, ovf_o}, 16'd0);

        // data: window 0
        wr(5'd5, 16'h1234, 1'b0);
        wr(5'd24, 16'hAAAA, 1'b0);
        wr(5'd16, 16'h0016, 1'b0);
        op(1'b1, 1'b0);
        rd("R2 global", 5'd5, 16'h1234);
        rd("R3 overlap", 5'd8, 16'hAAAA);
        rd("R4 local fresh", 5'd16, 16'h0000);
        wr(5'd16, 16'h5151, 1'b0);
        // R11 write with call uses old window 1
        wr(5'd16, 16'hBEEF, 1'b1);
        chk("R11 moved", 16'(cwp_o), 16'd2);
        rd("R11 new window clean", 5'd16, 16'h0000);
        op(1'b0, 1'b1);
        rd("R11 old window written", 5'd16, 16'hBEEF);
        op(1'b0, 1'b1);
        rd("R4 local private", 5'd16, 16'h0016);

        // R5 ring wrap
        op(1'b1, 1'b0);
        op(1'b1, 1'b0);
        op(1'b1, 1'b0);
        chk("R5 at last window", 16'(cwp_o), 16'd3);
        wr(5'd24, 16'h7777, 1'b0);
        rd("R5 last outgoing", 5'd24, 16'h7777);
        op(1'b0, 1'b1);
        op(1'b0, 1'b1);
        op(1'b0, 1'b1);
        rd("R5 wrap incoming", 5'd8, 16'h7777);

        // R10 bypass
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 5'd20; wr_data = 16'hCAFE;
        ra_sel = 5'd20; rb_sel = 5'd20;
        #1;
        chk("R10 port a", ra_data, 16'hCAFE);
        chk("R10 port b", rb_data, 16'hCAFE);
        rb_sel = 5'd5;
        #1;
        chk("R2 port b", rb_data, 16'h1234);
        @(negedge clk);
        wr_en = 1'b0;
        rd("R10 stored", 5'd20, 16'hCAFE);

        // R1 reset mid-run
        op(1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 rst cwp", 16'(cwp_o), 16'd0);
        chk("R1 rst mask", 16'(mask_o), 16'h0001);
        @(negedge clk);
        rst_n = 1'b1;
        rd("R1 rst regs", 5'd5, 16'h0000);

        finish_run();
    end
endmodule